// File: doc/BRIEF.md
# 66-bit Block Line Encoder with Self-Synchronizing Scrambler

This block turns a stream of 64-bit payload words into 66-bit line code words. Each incoming word has a flag that marks it as plain payload or as a control block. A control block is a word whose first 8 body bits hold a block type and whose other 56 bits hold control or data content; the caller builds it. The block adds a two-bit sync header that always contains one transition. It passes all 64 body bits through a self-synchronizing scrambler with polynomial x^58 + x^39 + 1. The scrambler state carries on from one word to the next.

The scrambler is defined serially with the least significant bit first. Each scrambled bit is the input bit XOR state bit 38 XOR state bit 57, and the scrambled bit is then shifted into state bit 0. The block unrolls this recurrence so that one whole word is done in one cycle. The header skips the scrambler.

Both sides use a valid/ready handshake. A single output slot is controlled by a two-state machine:
- `SLOT_EMPTY`: no word is held, `out_valid` is low and `in_ready` is high.
  - Transition `LOAD`: a word is accepted and the state moves to `SLOT_FULL`.
- `SLOT_FULL`: a word is held and `out_valid` is high.
  - Transition `PASS`: the held word is taken and a new word is accepted in the same cycle, so the state stays `SLOT_FULL`.
  - Transition `HOLD`: the held word is not taken, so the state stays `SLOT_FULL`.
  - Transition `DRAIN`: the held word is taken and no new word arrives, so the state moves to `SLOT_EMPTY`.

Reset is synchronous and returns the machine to `SLOT_EMPTY`.

Top module: `enc66_tx`

## Requirements
- R1: While reset is asserted at a clock edge, `out_valid` is low after that edge. After reset is released, `in_ready` is high.
- R2: A word accepted with `in_ctrl`=0 is emitted with `out_word[0]`=0 and `out_word[1]`=1. Bit 0 is sent first.
- R3: A word accepted with `in_ctrl`=1 is emitted with `out_word[0]`=1 and `out_word[1]`=0.
- R4: `out_word[65:2]` is the scrambled body. Body bit i (i = 0 to 63, LSB first) is `in_data[i]` XOR S[38] XOR S[57]. S is the scrambler state before that bit, and the result bit is then shifted into S[0].
- R5: The scrambler state carries from each accepted word into the next one with no reload between words.
- R6: The scrambler state changes only when a word is accepted (`in_valid` and `in_ready` both high). Cycles where a presented word is stalled leave later output unchanged.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` holds its value on the next cycle.
- R8: `in_ready` is high exactly when the slot is empty or `out_ready` is high. This allows one word per cycle.
- R9: Reset loads the scrambler state with the `SEED` parameter. Reset in the middle of a stream drops the held word.
- R10: The emitted header is never 00 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_ctrl | input | 1 | 1 = control block, 0 = payload |
| in_data | input | 64 | Payload or control block body |
| out_valid | output | 1 | `out_word` holds a code word |
| out_ready | input | 1 | Downstream takes the code word |
| out_word | output | 66 | Header in [1:0], scrambled body in [65:2] |

## Verification
The bench drives four kinds of data:
- Walking ones and walking zeros across all 64 positions. These show whether each body bit uses the right taps and the right bit order.
- An arithmetic (multiplicative) sequence. This mixes many bits so that state carried over between words shows up.
- Alternating all-zero and all-one words. These show whether the scrambler feeds back its output rather than its input.

The payload flag is varied within each kind so that the two header codes are exercised. The downstream ready signal is driven as:
- always high, which tests back-to-back throughput;
- with regular gaps;
- with long stall bursts while input stays valid, which shows whether the state advances on presentation rather than on acceptance.

A reset in the middle of the stream then checks that the seed is reloaded.

// File: rtl/enc66_pkg.sv
package enc66_pkg;

    localparam int BODY_W  = 64;
    localparam int HDR_W   = 2;
    localparam int WORD_W  = BODY_W + HDR_W;
    localparam int STATE_W = 58;
    localparam int TAP_LO  = 38;
    localparam int TAP_HI  = 57;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    // Header values as stored in out_word[1:0]; bit 0 goes on the line first.
    localparam logic [HDR_W-1:0] HDR_PAYLOAD = 2'b10;
    localparam logic [HDR_W-1:0] HDR_CONTROL = 2'b01;

    function automatic logic [HDR_W-1:0] pick_header(input logic is_ctrl);
        return is_ctrl ? HDR_CONTROL : HDR_PAYLOAD;
    endfunction

endpackage

// File: rtl/enc66_scrambler.sv
module enc66_scrambler #(
    parameter int          DATA_W  = 64,
    parameter int          STATE_W = 58,
    parameter int          TAP_LO  = 38,
    parameter int          TAP_HI  = 57,
    parameter logic [57:0] SEED    = 58'h155_5555_5555_5555
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    // Unrolled serial recurrence, LSB first.
    always_comb begin
        logic [STATE_W-1:0] walk;
        logic               bit_out;
        walk = state_q;
        dout = '0;
        for (int i = 0; i < DATA_W; i++) begin
            bit_out = din[i] ^ walk[TAP_LO] ^ walk[TAP_HI];
            dout[i] = bit_out;
            walk    = {walk[STATE_W-2:0], bit_out};
        end
        state_d = walk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED[STATE_W-1:0];
        end else if (advance) begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/enc66_framer.sv
module enc66_framer
    import enc66_pkg::*;
(
    input  logic              is_ctrl,
    input  logic [BODY_W-1:0] body,
    output logic [WORD_W-1:0] word
);

    always_comb begin
        word = {body, pick_header(is_ctrl)};
    end

endmodule

// File: rtl/enc66_slot_ctrl.sv
module enc66_slot_ctrl
    import enc66_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);

    slot_state_e state_q;
    slot_state_e state_d;

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and next-state process.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) begin          // LOAD
                    load    = 1'b1;
                    state_d = SLOT_FULL;
                end
            end
            SLOT_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && in_valid) begin        // PASS
                    load    = 1'b1;
                    state_d = SLOT_FULL;
                end else if (out_ready) begin           // DRAIN
                    state_d = SLOT_EMPTY;
                end else begin                          // HOLD
                    state_d = SLOT_FULL;
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

endmodule

// File: rtl/enc66_tx.sv
module enc66_tx
    import enc66_pkg::*;
#(
    parameter logic [STATE_W-1:0] SEED = 58'h155_5555_5555_5555
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_ctrl,
    input  logic [BODY_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);

    logic              load;
    logic [BODY_W-1:0] body_scr;
    logic [WORD_W-1:0] word_next;
    logic [WORD_W-1:0] word_q;

    enc66_slot_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    enc66_scrambler #(
        .DATA_W  (BODY_W),
        .STATE_W (STATE_W),
        .TAP_LO  (TAP_LO),
        .TAP_HI  (TAP_HI),
        .SEED    (SEED)
    ) u_scr (
        .clk     (clk),
        .rst     (rst),
        .advance (load),
        .din     (in_data),
        .dout    (body_scr)
    );

    enc66_framer u_frame (
        .is_ctrl (in_ctrl),
        .body    (body_scr),
        .word    (word_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_next;
        end
    end

    assign out_word = word_q;

endmodule

// File: rtl/enc66_tx_chk.sv
module enc66_tx_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_ctrl,
    input logic        out_valid,
    input logic        out_ready,
    input logic [65:0] out_word
);

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_payload_hdr_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_ctrl) |=> (out_word[1:0] == 2'b10));

    assert_control_hdr_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_ctrl) |=> (out_word[1:0] == 2'b01));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    assert_backpressure_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_hdr_transition_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[0] != out_word[1]));

endmodule

bind enc66_tx enc66_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_ctrl   (in_ctrl),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
);

// File: tb/enc66_tx_tb_top.sv
module enc66_tx_tb_top;

    localparam logic [57:0] SEED = 58'h155_5555_5555_5555;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_ctrl = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [65:0] out_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [57:0] model_st;
    logic [65:0] exp_q[$];

    always #5 clk = ~clk;

    enc66_tx #(.SEED(SEED)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctrl(in_ctrl), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word)
    );

    task automatic check(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent serial model of the scrambler and header.
    function automatic logic [65:0] model_word(input logic [63:0] d, input logic c, inout logic [57:0] st);
        logic [63:0] b;
        logic        o;
        for (int i = 0; i < 64; i++) begin
            o    = d[i] ^ st[38] ^ st[57];
            b[i] = o;
            st   = {st[56:0], o};
        end
        return {b, (c ? 2'b01 : 2'b10)};
    endfunction

    function automatic logic [63:0] pattern(input int w);
        int k = w % 64;
        case ((w / 64) % 4)
            0: return 64'd1 << k;
            1: return ~(64'd1 << k);
            2: return 64'(w) * 64'h9E37_79B9_7F4A_7C15;
            default: return k[0] ? '1 : '0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(out_valid === 1'b0, "R1 out_valid in reset", {65'd0, out_valid}, 66'd0);
        rst = 1'b0;
        model_st = SEED;
        exp_q.delete();
        #1;
        check(in_ready === 1'b1, "R1 R9 in_ready after reset", {65'd0, in_ready}, 66'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int w = 0;
        do_reset();
        for (int it = 0; it < 1400; it++) begin
            if (it == 900) begin
                do_reset();   // R9: mid-stream reset reloads the seed
            end
            @(negedge clk);
            in_valid  = (it % 7) != 3;
            in_data   = pattern(w);
            in_ctrl   = ((w / 3) % 2) == 1;
            if (it < 300)       out_ready = 1'b1;
            else if (it < 600)  out_ready = (it % 3) != 0;
            else                out_ready = ((it / 9) % 2) == 0;   // stall bursts (R6)
            #1;
            check(in_ready === (!out_valid || out_ready), "R8 in_ready",
                  {65'd0, in_ready}, {65'd0, (!out_valid || out_ready)});
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected out_valid", out_word, 66'd0);
                end else begin
                    check(out_word === exp_q[0], "R2 R3 R4 R5 R6 R7 R9 out_word", out_word, exp_q[0]);
                    check(out_word[0] != out_word[1], "R10 header", out_word, exp_q[0]);
                    if (out_ready) void'(exp_q.pop_front());
                end
            end else begin
                check(exp_q.size() == 0, "R7 word lost", 66'(exp_q.size()), 66'd0);
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(model_word(in_data, in_ctrl, model_st));
                w++;
            end
        end
        // Drain.
        for (int it = 0; it < 4; it++) begin
            @(negedge clk);
            in_valid = 1'b0; out_ready = 1'b1;
            #1;
            if (out_valid && exp_q.size() != 0) begin
                check(out_word === exp_q[0], "R4 drain word", out_word, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
        @(negedge clk);
        #1;
        check(!out_valid && exp_q.size() == 0, "R8 drained",
              {65'd0, out_valid}, 66'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule